// File: doc/BRIEF.md
# Four-Times Interpolating FIR Filter

The block raises the sample rate of one audio channel by a factor of four. Each 16-bit two's-complement input sample enters a 24-entry delay line. For every input sample the block then computes four output samples, one per interpolation phase. All four phases share a single multiply-accumulate engine. The delay line recirculates past this engine, and the 12-bit coefficients come from a fixed table that is computed in logic. A stereo system instantiates the block once per channel.

Each output phase takes 24 products. The exact sum is clamped to a 28-bit signed range, and the 14 most significant bits of the clamped value become the output. The output is then formatted:

- An optional fixed DC offset can be added to the output, with saturation.
- The output word is presented as either two's complement or offset binary.

A one-cycle strobe marks each new output word. While the engine works through its 96 cycles, a busy flag is high. A new input is accepted only when the previous sample's four phases are complete.

Top module: `os4_fir_interp`

## Requirements
- R1: After reset, `busy` and `out_strobe` are low and the held output value is zero. `out_sample` therefore reads 14'h0000 in two's-complement format and 14'h2000 in offset-binary format.
- R2: A sample on `in_sample` is accepted at a rising edge where `in_valid` is high and `busy` is low. `busy` is high for exactly the 96 cycles that follow the accepting edge.
- R3: Each accepted sample produces exactly four outputs, each marked by a one-cycle `out_strobe` pulse. Counting the accepting edge as edge 0, the pulses follow edges 24, 48, 72 and 96, in phase order 0, 1, 2, 3.
- R4: Phase p (0..3) computes S = sum over k=0..23 of x[n-k]*c[4k+p]. Here x[n] is the newest accepted sample, samples older than reset count as 0, and the coefficients are c[i] = 42*min(i+1, 96-i) for i = 0..95.
- R5: The output value is the clamped sum shifted arithmetically right by 14, which is bits 27:14 of a 28-bit word.
- R6: Sums above 2^27-1 or below -2^27 saturate. The output value is then 8191 or -8192 and never wraps.
- R7: When `dc_offset_en` is high at the edge that produces an output, 492 (about 3% of full scale) is added to the output value, saturating at 8191.
- R8: When `fmt_offset_bin` is 1, `out_sample` is the held value with bit 13 inverted (offset binary); when it is 0, the value is two's complement. The selection acts combinationally. Between strobes the held value does not change.
- R9: `in_valid` while `busy` is high is ignored: the sample enters neither the delay line nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Offers `in_sample` for acceptance |
| in_sample | input | 16 | Two's-complement input sample |
| fmt_offset_bin | input | 1 | 1 selects offset-binary output |
| dc_offset_en | input | 1 | 1 adds the fixed DC offset |
| busy | output | 1 | Engine computing the four phases |
| out_sample | output | 14 | Output sample in the selected format |
| out_strobe | output | 1 | One-cycle pulse per new output word |

## Verification
The following properties are checked on every cycle:

- `busy` never lasts more than 96 cycles.
- No accepted sample yields more than four strobes.
- An accepting edge always raises `busy`.
- The output holds between strobes.
- A change of format only flips bit 13.

The arithmetic depends on the whole sample history, so it is shown only by the bench scenarios. These are:

- an impulse;
- steady and alternating inputs;
- positive and negative full-scale runs that saturate;
- offset runs near the top of the range;
- an input offered during `busy`, checked through the four outputs that follow.

// File: rtl/os4_pkg.sv
package os4_pkg;
  localparam int DW         = 16;
  localparam int CW         = 12;
  localparam int OW         = 14;
  localparam int TAPS       = 24;
  localparam int PHASES     = 4;
  localparam int NCOEF      = TAPS * PHASES;
  localparam int PW         = DW + CW;
  localparam int GUARD      = 5;
  localparam int AW         = PW + GUARD;
  localparam int COEF_STEP  = 42;
  localparam int DC_OFFSET  = 492;
  localparam int TAP_W      = $clog2(TAPS);
  localparam int PH_W       = $clog2(PHASES);
  localparam int IDX_W      = $clog2(NCOEF);

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} os4_state_t;

  // Symmetric triangular placeholder low-pass response.
  function automatic logic signed [CW-1:0] coef_at(input logic [IDX_W-1:0] idx);
    int i;
    int m;
    i = int'(idx);
    m = (i + 1 < NCOEF - i) ? i + 1 : NCOEF - i;
    return CW'(m * COEF_STEP);
  endfunction
endpackage

// File: rtl/os4_ctrl.sv
module os4_ctrl
  import os4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             accept,
  output logic             mac_en,
  output logic             first,
  output logic             last,
  output logic [TAP_W-1:0] tap,
  output logic [PH_W-1:0]  phase,
  output logic             busy
);
  os4_state_t       state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [PH_W-1:0]  ph_q, ph_d;

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    ph_d    = ph_q;
    accept  = 1'b0;
    mac_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          accept  = 1'b1;
          state_d = ST_RUN;
          tap_d   = '0;
          ph_d    = '0;
        end
      end
      ST_RUN: begin
        mac_en = 1'b1;
        if (tap_q == TAP_W'(TAPS - 1)) begin
          tap_d = '0;
          ph_d  = ph_q + 1'b1;
          if (ph_q == PH_W'(PHASES - 1)) state_d = ST_IDLE;
        end else begin
          tap_d = tap_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      ph_q    <= ph_d;
    end
  end

  assign first = (tap_q == '0);
  assign last  = (tap_q == TAP_W'(TAPS - 1));
  assign tap   = tap_q;
  assign phase = ph_q;
  assign busy  = (state_q == ST_RUN);
endmodule

// File: rtl/os4_delay_line.sv
module os4_delay_line
  import os4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 rotate,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] head
);
  logic signed [DW-1:0] cell_q [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_cell
    logic signed [DW-1:0] cell_d;
    always_comb begin
      cell_d = cell_q[g];
      if (load) cell_d = (g == 0) ? din : cell_q[(g + TAPS - 1) % TAPS];
      else if (rotate) cell_d = cell_q[(g + 1) % TAPS];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q[g] <= '0;
      else if (load || rotate) cell_q[g] <= cell_d;
    end
  end

  assign head = cell_q[0];
endmodule

// File: rtl/os4_mac.sv
module os4_mac
  import os4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic                 last,
  input  logic                 dc_en,
  input  logic signed [DW-1:0] head,
  input  logic signed [CW-1:0] coef,
  output logic signed [OW-1:0] result,
  output logic                 strobe
);
  localparam logic signed [AW-1:0] SAT_HI = AW'((64'sd1 <<< (PW - 1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = -AW'(64'sd1 <<< (PW - 1));
  localparam logic signed [OW:0]   OUT_HI = (OW+1)'((1 <<< (OW - 1)) - 1);

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_q, sum_d, clamp;
  logic signed [OW-1:0] top_bits, res_d;
  logic signed [OW:0]   shifted;
  logic                 strobe_d;

  always_comb begin
    prod  = head * coef;
    sum_d = (first ? '0 : acc_q) + {{GUARD{prod[PW-1]}}, prod};
    if (sum_d > SAT_HI)      clamp = SAT_HI;
    else if (sum_d < SAT_LO) clamp = SAT_LO;
    else                     clamp = sum_d;
    top_bits = clamp[PW-1 -: OW];
    shifted  = {top_bits[OW-1], top_bits} + (dc_en ? (OW+1)'(DC_OFFSET) : '0);
    res_d    = (shifted > OUT_HI) ? OUT_HI[OW-1:0] : shifted[OW-1:0];
    strobe_d = en && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      result <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= strobe_d;
      if (en) acc_q <= sum_d;
      if (strobe_d) result <= res_d;
    end
  end
endmodule

// File: rtl/os4_fir_interp.sv
module os4_fir_interp
  import os4_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   in_sample,
  input  logic          fmt_offset_bin,
  input  logic          dc_offset_en,
  output logic          busy,
  output logic [13:0]   out_sample,
  output logic          out_strobe
);
  logic                 accept, mac_en, first, last;
  logic [TAP_W-1:0]     tap;
  logic [PH_W-1:0]      phase;
  logic signed [DW-1:0] head;
  logic signed [CW-1:0] coef;
  logic signed [OW-1:0] result;
  logic [IDX_W-1:0]     cidx;

  os4_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .accept(accept),
    .mac_en(mac_en), .first(first), .last(last), .tap(tap),
    .phase(phase), .busy(busy)
  );

  os4_delay_line u_dline (
    .clk(clk), .rst_n(rst_n), .load(accept), .rotate(mac_en),
    .din(in_sample), .head(head)
  );

  assign cidx = IDX_W'(tap) * IDX_W'(PHASES) + IDX_W'(phase);
  assign coef = coef_at(cidx);

  os4_mac u_mac (
    .clk(clk), .rst_n(rst_n), .en(mac_en), .first(first), .last(last),
    .dc_en(dc_offset_en), .head(head), .coef(coef), .result(result),
    .strobe(out_strobe)
  );

  assign out_sample = fmt_offset_bin ? {~result[OW-1], result[OW-2:0]} : result;
endmodule

// File: rtl/os4_fir_interp_chk.sv
module os4_fir_interp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        fmt_offset_bin,
  input logic        busy,
  input logic [13:0] out_sample,
  input logic        out_strobe
);
  localparam int BUSY_MAX = 96;
  localparam int OUT_MAX  = 4;

  logic [7:0] busy_run;
  logic [3:0] strobe_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run   <= '0;
      strobe_cnt <= '0;
    end else begin
      busy_run <= busy ? busy_run + 1'b1 : '0;
      if (in_valid && !busy) strobe_cnt <= '0;
      else if (out_strobe)   strobe_cnt <= strobe_cnt + 1'b1;
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 8'(BUSY_MAX)); // R2

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy); // R2

  AST_FOUR_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_cnt <= 4'(OUT_MAX)); // R3

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe); // R3

  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_strobe && $stable(fmt_offset_bin)) |-> $stable(out_sample)); // R8

  AST_FORMAT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_strobe && !$stable(fmt_offset_bin)) |->
      (out_sample == ($past(out_sample) ^ 14'h2000))); // R8
endmodule

bind os4_fir_interp os4_fir_interp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .fmt_offset_bin(fmt_offset_bin), .busy(busy),
  .out_sample(out_sample), .out_strobe(out_strobe)
);

// File: tb/os4_fir_interp_tb.sv
module os4_fir_interp_tb;
  logic        clk, rst_n, in_valid, fmt_offset_bin, dc_offset_en;
  logic [15:0] in_sample;
  logic        busy, out_strobe;
  logic [13:0] out_sample;

  int n_checks = 0;
  int n_fail   = 0;
  longint hist [24];

  os4_fir_interp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .fmt_offset_bin(fmt_offset_bin), .dc_offset_en(dc_offset_en),
    .busy(busy), .out_sample(out_sample), .out_strobe(out_strobe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint coef(input int i);
    return 42 * (((i + 1) < (96 - i)) ? (i + 1) : (96 - i));
  endfunction

  function automatic longint expect_out(input int p);
    longint s, v;
    s = 0;
    for (int k = 0; k < 24; k++) s += hist[k] * coef(4 * k + p);
    if (s > 134217727) s = 134217727;
    if (s < -134217728) s = -134217728;
    v = s >>> 14;
    if (dc_offset_en) begin
      v += 492;
      if (v > 8191) v = 8191;
    end
    v = v & 14'h3fff;
    if (fmt_offset_bin) v = v ^ 14'h2000;
    return v;
  endfunction

  // Push one sample; optionally offer a spurious sample during busy (R9).
  task automatic push(input logic signed [15:0] x, input string req,
                      input bit inject);
    int guard = 0;
    while (busy && guard < 200) begin @(negedge clk); guard++; end
    in_valid  = 1'b1;
    in_sample = x;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 busy after accept", busy, 1);
    for (int k = 23; k > 0; k--) hist[k] = hist[k - 1];
    hist[0] = longint'(x);
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 22; c++) begin
        if (inject && p == 1 && c == 3) begin
          in_valid = 1'b1; in_sample = 16'sh7fff;
        end else begin
          in_valid = 1'b0;
        end
        @(negedge clk);
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R3 strobe low before output", out_strobe, 0);
      @(negedge clk);
      check("R3 strobe on output", out_strobe, 1);
      check(req, out_sample, expect_out(p));
    end
    check("R2 busy drop after 96", busy, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    fmt_offset_bin = 1'b0; dc_offset_en = 1'b0;
    for (int k = 0; k < 24; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 busy", busy, 0);
    check("R1 strobe", out_strobe, 0);
    check("R1 out twos", out_sample, 14'h0000);
    fmt_offset_bin = 1'b1; #1;
    check("R1 R8 out offset-binary", out_sample, 14'h2000);
    fmt_offset_bin = 1'b0;
  endtask

  task automatic t_impulse();
    do_reset();
    push(16'sd20000, "R4 impulse", 0);
    for (int i = 0; i < 3; i++) push(16'sd0, "R4 impulse tail", 0);
    push(-16'sd3000, "R4 R5 negative", 0);
    push(16'sd3000, "R4 alternating", 0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 24; i++) push(16'sh7fff, "R6 positive", 0);
    check("R6 clamp high", out_sample, 14'h1fff);
    for (int i = 0; i < 24; i++) push(-16'sh8000, "R6 negative", 0);
    check("R6 clamp low", out_sample, 14'h2000);
  endtask

  task automatic t_offset_format();
    do_reset();
    dc_offset_en = 1'b1;
    for (int i = 0; i < 6; i++) push(16'sd1500, "R7 offset", 0);
    for (int i = 0; i < 24; i++) push(16'sh7fff, "R7 offset saturate", 0);
    check("R7 offset clamp", out_sample, 14'h1fff);
    fmt_offset_bin = 1'b1;
    for (int i = 0; i < 4; i++) push(-16'sd9000, "R8 offset binary", 0);
    @(negedge clk);
    fmt_offset_bin = 1'b0; #1;
    check("R8 comb format flip", out_sample, expect_out(3));
    dc_offset_en = 1'b0;
  endtask

  task automatic t_ignore_busy();
    do_reset();
    push(16'sd8000, "R9 ignore busy", 1);
    push(16'sd100, "R9 history unchanged", 0);
    push(-16'sd100, "R9 history unchanged", 0);
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_saturate();
    t_offset_format();
    t_ignore_busy();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule